// File: doc/BRIEF.md
# Multi-mode pixel port unpacker

This block sits on a 16-bit pixel input bus beside a blanking input and a mode-mix input. Every rising edge of the pixel clock captures one input word. Depending on the selected format, it takes one, two or three words to build a pixel. The block gathers those words and produces a 24-bit colour word with red in the top byte, green in the middle byte and blue in the low byte. For the indexed format it produces an 8-bit palette index in the low byte instead.

Two 3-bit mode inputs hold a primary and a secondary format. The mix input chooses between them at pixel granularity. When blanking is active, the output is forced to black and flagged as blanked. Each completed pixel is marked by a one-cycle valid strobe.

Top module: `pix_unpack`

## Requirements
- R1: When the last word of a pixel is captured, `out_valid` is high for exactly the following cycle and `out_rgb` carries that pixel. After a non-final word, `out_valid` is low.
- R2: While `rst_n` is low, `out_valid` is 0, `out_rgb` is 0 and `out_blank` is 1.
- R3: A clock edge that samples `blank_n` low makes `out_blank` 1, `out_rgb` 0 and `out_valid` 0 in the next cycle.
- R4: The first word sampled with `blank_n` high after a low sample is always word 0 of a new pixel, and any partially received pixel is discarded.
- R5: Mode code 0 (indexed) completes on every word, with `out_rgb` = {16'h0, pix_in[7:0]}.
- R6: Mode code 1 uses two bytes on pix_in[7:0]. With byte A first and byte B second, the output is red = {B[6:2],000}, green = {B[1:0],A[7:5],000} and blue = {A[4:0],000}. B[7] is ignored.
- R7: Mode code 2 uses two bytes A then B. The output is red = {B[7:3],000}, green = {B[2:0],A[7:5],00} and blue = {A[4:0],000}.
- R8: Mode code 3 uses three bytes on pix_in[7:0], arriving blue first, then green, then red, each taken as a full 8-bit channel.
- R9: Mode code 4 uses a single word. Red = {pix_in[14:10],000}, green = {pix_in[9:5],000} and blue = {pix_in[4:0],000}. pix_in[15] is ignored.
- R10: Mode code 5 uses a single word. Red = {pix_in[15:11],000}, green = {pix_in[10:5],00} and blue = {pix_in[4:0],000}.
- R11: `mix_sel` low on a pixel's first word selects `mode_pri`, and high selects `mode_sec`. The choice is held for the rest of that pixel, whatever `mix_sel` does later.
- R12: Mode codes 6 and 7 behave as mode code 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_in | input | 16 | Pixel input word |
| blank_n | input | 1 | High during active display, low while blanked |
| mix_sel | input | 1 | Chooses the secondary mode when high |
| mode_pri | input | 3 | Primary format code |
| mode_sec | input | 3 | Secondary format code |
| out_rgb | output | 24 | Assembled {red, green, blue} or index in the low byte |
| out_valid | output | 1 | One-cycle strobe for a completed pixel |
| out_blank | output | 1 | Output is blanked |

## Verification
The bench targets a blanking gap that arrives after only part of a multi-byte pixel. A design that does not restart framing would mix the stale bytes into the next pixel, or strobe valid one word early.

It also toggles the mix input between the words of a single pixel. A design that does not hold the format would switch layout midway and produce a wrong colour or a wrong word count.

Random bytes exercise every bit position of the scrambled two-byte layouts and the ignored top bits. A swapped or shifted field therefore shows up as a channel mismatch. The unused mode codes are also driven, to catch a decoder that treats them as multi-word formats.

// File: rtl/pix_unpack.sv
module pix_unpack #(
  parameter int WORD_W = 16,
  parameter int CH_W   = 8,
  parameter int MODE_W = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [WORD_W-1:0]   pix_in,
  input  logic                blank_n,
  input  logic                mix_sel,
  input  logic [MODE_W-1:0]   mode_pri,
  input  logic [MODE_W-1:0]   mode_sec,
  output logic [3*CH_W-1:0]   out_rgb,
  output logic                out_valid,
  output logic                out_blank
);
  localparam int RGB_W = 3 * CH_W;

  logic              blank_d;
  logic [1:0]        phase_q;
  logic [MODE_W-1:0] mode_q;
  logic [CH_W-1:0]   b0_q, b1_q;
  logic [1:0]        last_ph;
  logic [RGB_W-1:0]  asm_rgb;

  wire              rise      = blank_n & ~blank_d;
  wire [1:0]        cur_phase = rise ? 2'd0 : phase_q;
  wire [MODE_W-1:0] sel_mode  = mix_sel ? mode_sec : mode_pri;
  wire [MODE_W-1:0] cur_mode  = (cur_phase == 2'd0) ? sel_mode : mode_q;
  wire [CH_W-1:0]   cb        = pix_in[CH_W-1:0];
  wire              last      = cur_phase >= last_ph;

  always_comb begin
    case (cur_mode)
      3'd1, 3'd2: last_ph = 2'd1;
      3'd3:       last_ph = 2'd2;
      default:    last_ph = 2'd0;
    endcase
  end

  always_comb begin
    case (cur_mode)
      3'd1: asm_rgb = {cb[6:2], 3'b0, cb[1:0], b0_q[7:5], 3'b0, b0_q[4:0], 3'b0};
      3'd2: asm_rgb = {cb[7:3], 3'b0, cb[2:0], b0_q[7:5], 2'b0, b0_q[4:0], 3'b0};
      3'd3: asm_rgb = {cb, b1_q, b0_q};
      3'd4: asm_rgb = {pix_in[14:10], 3'b0, pix_in[9:5], 3'b0, pix_in[4:0], 3'b0};
      3'd5: asm_rgb = {pix_in[15:11], 3'b0, pix_in[10:5], 2'b0, pix_in[4:0], 3'b0};
      default: asm_rgb = {{(RGB_W-CH_W){1'b0}}, cb};
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      blank_d   <= 1'b0;
      phase_q   <= 2'd0;
      mode_q    <= '0;
      b0_q      <= '0;
      b1_q      <= '0;
      out_rgb   <= '0;
      out_valid <= 1'b0;
      out_blank <= 1'b1;
    end else begin
      blank_d <= blank_n;
      if (!blank_n) begin
        phase_q   <= 2'd0;
        out_rgb   <= '0;
        out_valid <= 1'b0;
        out_blank <= 1'b1;
      end else begin
        out_blank <= 1'b0;
        if (cur_phase == 2'd0) begin
          mode_q <= sel_mode;
          b0_q   <= cb;
        end
        if (cur_phase == 2'd1) b1_q <= cb;
        phase_q   <= last ? 2'd0 : 2'(cur_phase + 2'd1);
        out_valid <= last;
        if (last) out_rgb <= asm_rgb;
      end
    end
  end
endmodule

module pix_unpack_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] pix_in,
  input logic        blank_n,
  input logic        mix_sel,
  input logic [2:0]  mode_pri,
  input logic [2:0]  mode_sec,
  input logic [23:0] out_rgb,
  input logic        out_valid,
  input logic        out_blank
);
  p_blank_black_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !blank_n |=> (out_blank && out_rgb == 24'h0 && !out_valid));

  p_valid_not_blank_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !out_blank);

  p_restart_first_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (blank_n && !$past(blank_n) && mode_pri == 3'd3 && mode_sec == 3'd3) |=> !out_valid);

  p_index_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (blank_n && !$past(blank_n) && mode_pri == 3'd0 && mode_sec == 3'd0)
    |=> (out_valid && out_rgb == {16'h0, $past(pix_in[7:0])}));

  p_two_byte_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (blank_n && $past(blank_n) && !$past(blank_n, 2) && mode_pri == 3'd2 && mode_sec == 3'd2
     && $past(mode_pri) == 3'd2 && $past(mode_sec) == 3'd2) |=> out_valid);

  p_word16_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (blank_n && !$past(blank_n) && mode_pri == 3'd5 && mode_sec == 3'd5)
    |=> (out_valid && out_rgb == {$past(pix_in[15:11]), 3'b0, $past(pix_in[10:5]), 2'b0,
                                  $past(pix_in[4:0]), 3'b0}));
endmodule

bind pix_unpack pix_unpack_chk u_chk (.*);

// File: tb/pix_unpack_tb.sv
module pix_unpack_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] pix_in = '0;
  logic        blank_n = 1'b0;
  logic        mix_sel = 1'b0;
  logic [2:0]  mode_pri = '0;
  logic [2:0]  mode_sec = '0;
  logic [23:0] out_rgb;
  logic        out_valid;
  logic        out_blank;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  pix_unpack u_dut (.*);

  function automatic int nwords(input logic [2:0] m);
    case (m)
      3'd1, 3'd2: return 2;
      3'd3:       return 3;
      default:    return 1;
    endcase
  endfunction

  function automatic logic [23:0] exp_rgb(input logic [2:0] m, input logic [15:0] a, b, c);
    case (m)
      3'd1: return {b[6:2], 3'b0, b[1:0], a[7:5], 3'b0, a[4:0], 3'b0};
      3'd2: return {b[7:3], 3'b0, b[2:0], a[7:5], 2'b0, a[4:0], 3'b0};
      3'd3: return {c[7:0], b[7:0], a[7:0]};
      3'd4: return {a[14:10], 3'b0, a[9:5], 3'b0, a[4:0], 3'b0};
      3'd5: return {a[15:11], 3'b0, a[10:5], 2'b0, a[4:0], 3'b0};
      default: return {16'h0, a[7:0]};
    endcase
  endfunction

  function automatic string mtag(input logic [2:0] m);
    case (m)
      3'd0: return "R5";
      3'd1: return "R6";
      3'd2: return "R7";
      3'd3: return "R8";
      3'd4: return "R9";
      3'd5: return "R10";
      default: return "R12";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic drive(input logic [15:0] w, input logic b, input logic m);
    @(negedge clk);
    pix_in = w; blank_n = b; mix_sel = m;
    @(posedge clk);
    #1;
  endtask

  task automatic blank_word();
    drive(16'($urandom), 1'b0, 1'($urandom));
    chk("R3 blank", out_blank, 1);
    chk("R3 rgb", out_rgb, 0);
    chk("R3 valid", out_valid, 0);
  endtask

  task automatic do_pixel(input logic [2:0] pri, input logic [2:0] sec, input logic m, input logic wiggle);
    logic [15:0] w [3];
    logic [2:0] md;
    int n;
    mode_pri = pri; mode_sec = sec;
    md = m ? sec : pri;
    n = nwords(md);
    for (int k = 0; k < 3; k++) w[k] = 16'($urandom);
    for (int k = 0; k < n; k++) begin
      drive(w[k], 1'b1, (k == 0) ? m : (wiggle ? ~m : m));
      if (k < n - 1) chk("R1 mid", out_valid, 0);
      else begin
        chk("R1 valid", out_valid, 1);
        chk((m && wiggle) ? "R11" : mtag(md), out_rgb, exp_rgb(md, w[0], w[1], w[2]));
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] wa, wb;
    logic [23:0] r1, r2;
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    #1;
    chk("R2 valid", out_valid, 0);
    chk("R2 rgb", out_rgb, 0);
    chk("R2 blank", out_blank, 1);
    @(negedge clk);
    rst_n = 1'b1;

    // every mode directly, primary path
    for (int md = 0; md < 8; md++) begin
      blank_word();
      do_pixel(3'(md), 3'(7 - md), 1'b0, 1'b0);
      do_pixel(3'(md), 3'(7 - md), 1'b0, 1'b0);
    end

    // restart on blank: partial 24-bit pixel dropped (R4)
    blank_word();
    mode_pri = 3'd3; mode_sec = 3'd3;
    drive(16'h00aa, 1'b1, 1'b0);
    drive(16'h00bb, 1'b1, 1'b0);
    chk("R4 partial", out_valid, 0);
    blank_word();
    drive(16'h0011, 1'b1, 1'b0);
    chk("R4 w0", out_valid, 0);
    drive(16'h0022, 1'b1, 1'b0);
    chk("R4 w1", out_valid, 0);
    drive(16'h0033, 1'b1, 1'b0);
    chk("R4 valid", out_valid, 1);
    chk("R4 rgb", out_rgb, 24'h332211);

    // partial two-byte pixel then blank (R4)
    mode_pri = 3'd2;
    drive(16'h00ff, 1'b1, 1'b0);
    drive(16'h00ff, 1'b1, 1'b0);
    drive(16'h00ff, 1'b1, 1'b0);
    blank_word();
    drive(16'h0000, 1'b1, 1'b0);
    chk("R4 two-byte w0", out_valid, 0);
    drive(16'h0000, 1'b1, 1'b0);
    chk("R4 two-byte rgb", out_rgb, 24'h0);

    // secondary select held across words (R11)
    blank_word();
    do_pixel(3'd0, 3'd3, 1'b1, 1'b1);
    do_pixel(3'd3, 3'd1, 1'b1, 1'b1);
    do_pixel(3'd5, 3'd2, 1'b1, 1'b1);
    do_pixel(3'd2, 3'd5, 1'b0, 1'b1);

    // ignored top bit in single-word 15-bit (R9)
    blank_word();
    mode_pri = 3'd4; mode_sec = 3'd4;
    wa = 16'($urandom) & 16'h7fff; wb = wa | 16'h8000;
    drive(wa, 1'b1, 1'b0); r1 = out_rgb;
    drive(wb, 1'b1, 1'b0); r2 = out_rgb;
    chk("R9 bit15", r2, r1);

    // random lines
    for (int ln = 0; ln < 300; ln++) begin
      logic [2:0] p, s;
      p = 3'($urandom); s = 3'($urandom);
      blank_word();
      for (int px = 0; px < 1 + ($urandom % 6); px++)
        do_pixel(p, s, 1'($urandom), 1'($urandom));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule